// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front End

This block is the device-side front end of a small serial EEPROM. It watches the three bus pins (select, serial clock and serial data in), all sampled by a faster system clock. It finds the start of an instruction and assembles the opcode, the address and the write data. From these it decodes seven instructions: read, write, erase, write-enable, write-disable, erase-all and write-all. A write-enable latch guards every instruction that changes memory. Reads are served from a local array and stream out on the serial data pin, which has a separate output-enable in place of a tri-state driver.

An instruction that changes memory is only armed once exactly the right number of serial clock pulses has arrived. It fires when select falls, and no clock edge may come in between. It then shows up as a one-cycle strobe with its address and data toward a program-cycle controller, and the local array is updated at the same time. A byte/word organisation input sets the address width and the data unit: words are 16 bits and bytes are 8 bits.

Top module: `eepr_front`

## Requirements
- R1: After reset the write-enable latch is clear, every array bit reads as 1, the output-enable is low and no strobe is active.
- R2: A frame opens only when select rises while the serial clock is low. If select rises while the clock is high, every pin activity is ignored until select goes low again.
- R3: Once a frame is open, zeros on the data pin at clock rising edges are skipped. The first 1 is the start bit. Every following bit is taken at a serial clock rising edge.
- R4: After the start bit come two opcode bits, first bit first: 10 is read, 01 is write, 11 is erase, 00 is the extended group. In the extended group the two most significant address bits select: 00 disable, 01 write-all, 10 erase-all, 11 enable.
- R5: With the organisation input high (word mode) the address has ADDR_W bits and the unit is 16 bits. With it low (byte mode) the address has ADDR_W+1 bits and the unit is 8 bits. Byte address bit 0 picks the word half: 0 is bits 7..0 and 1 is bits 15..8.
- R6: For a read, the rising edge that takes the last address bit drives the output to a 0 with the output-enable high. Each later rising edge presents the next data bit, most significant bit first.
- R7: While select stays high, a read goes on to the next address after the last bit of a unit, with no extra 0 bit. It wraps from the top address to address 0.
- R8: Write, erase, write-all and erase-all neither strobe nor change the array unless enable has executed since reset or since the last disable. Read is unaffected by the latch.
- R9: An instruction that changes memory or the latch executes when select falls after its last bit. A further clock rising edge before select falls cancels it.
- R10: Select falling at any point ends the frame without effect. The output-enable is low from four system clocks after select goes low, and it is high only during read data.
- R11: An executed write, erase, write-all or erase-all gives a single one-cycle strobe for that instruction only. The strobe comes with the received address, the data (zero-extended in byte mode) and the organisation.
- R12: Erase sets the addressed unit to all ones. Erase-all sets the whole array to ones. Write-all writes the data unit to every address; in byte mode the byte is copied to both word halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select, active high |
| sclk_i | input | 1 | Serial clock from the bus master |
| sdi_i | input | 1 | Serial data in |
| org_word_i | input | 1 | Organisation: 1 word mode, 0 byte mode |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output-enable for serial data out |
| prog_write_o | output | 1 | One-cycle write strobe |
| prog_erase_o | output | 1 | One-cycle erase strobe |
| prog_erase_all_o | output | 1 | One-cycle erase-all strobe |
| prog_write_all_o | output | 1 | One-cycle write-all strobe |
| prog_addr_o | output | ADDR_W+1 | Address received with the strobed instruction |
| prog_data_o | output | 16 | Data received with the strobed instruction |
| prog_word_o | output | 1 | Organisation latched for the frame |

## Verification
A frame state that is off by even one bit count shows on the next read frame. The dummy 0 then appears one edge early or late, or a program instruction fails to arm, and so no strobe follows select falling about three system clocks later. A corrupt latch or a wrong row in the array goes unseen until a strobe is missed or extra, or until a later read returns the wrong unit, so readbacks follow every program step. A stuck output-enable is caught within four system clocks of select going low.

// File: rtl/eepr_pkg.sv
package eepr_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_DEAD
  } fsm_t;

  typedef enum logic [2:0] {
    CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN, CMD_WDS, CMD_ERAL, CMD_WRAL
  } cmd_t;

  // opcode plus the two top address bits for the extended group
  function automatic cmd_t decode_cmd(logic [1:0] op, logic [1:0] ext);
    cmd_t c;
    case (op)
      2'b10: c = CMD_READ;
      2'b01: c = CMD_WRITE;
      2'b11: c = CMD_ERASE;
      default: begin
        case (ext)
          2'b00: c = CMD_WDS;
          2'b01: c = CMD_WRAL;
          2'b10: c = CMD_ERAL;
          default: c = CMD_WEN;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/eepr_sampler.sv
module eepr_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic s_r,
  output logic c_r,
  output logic d_r,
  output logic c_rise,
  output logic s_rise
);
  logic [SYNC_STAGES-1:0] s_sync, c_sync, d_sync;
  logic s_prev, c_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sync <= '0;
      c_sync <= '0;
      d_sync <= '0;
      s_prev <= 1'b0;
      c_prev <= 1'b0;
    end else begin
      s_sync <= {s_sync[SYNC_STAGES-2:0], sel_pin};
      c_sync <= {c_sync[SYNC_STAGES-2:0], sclk_pin};
      d_sync <= {d_sync[SYNC_STAGES-2:0], sdi_pin};
      s_prev <= s_sync[SYNC_STAGES-1];
      c_prev <= c_sync[SYNC_STAGES-1];
    end
  end

  assign s_r    = s_sync[SYNC_STAGES-1];
  assign c_r    = c_sync[SYNC_STAGES-1];
  assign d_r    = d_sync[SYNC_STAGES-1];
  assign c_rise = c_r & ~c_prev;
  assign s_rise = s_r & ~s_prev;

endmodule

// File: rtl/eepr_frame.sv
module eepr_frame
  import eepr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_r,
  input  logic                c_r,
  input  logic                d_r,
  input  logic                c_rise,
  input  logic                s_rise,
  input  logic                org_word_i,
  output logic                rd_go,
  output logic [ADDR_W:0]     rd_go_addr,
  output logic                rd_active,
  output logic                org_q,
  output logic [3:0]          stb_q,
  output logic [ADDR_W:0]     cmd_addr_q,
  output logic [WORD_W-1:0]   cmd_data_q
);
  localparam int AWB = ADDR_W + 1;
  localparam int SRW = (AWB + 2 > WORD_W) ? AWB + 2 : WORD_W;
  localparam int CW  = $clog2(SRW + 1) + 1;
  localparam logic [CW-1:0] HDR_WORD = CW'(ADDR_W + 2);
  localparam logic [CW-1:0] HDR_BYTE = CW'(AWB + 2);
  localparam logic [CW-1:0] DAT_WORD = CW'(WORD_W);
  localparam logic [CW-1:0] DAT_BYTE = CW'(BYTE_W);

  fsm_t              state, state_n;
  cmd_t              cmd_q, cmd_n, hdr_cmd;
  logic [CW-1:0]     cnt, cnt_n, cnt_inc, hdr_len, dat_len;
  logic [SRW-1:0]    sr, sr_n, shifted;
  logic              org_n, wen_q, wen_n;
  logic [3:0]        stb_n;
  logic [AWB-1:0]    addr_n, hdr_addr;
  logic [WORD_W-1:0] data_n;
  logic [1:0]        hdr_op, hdr_ext;

  assign shifted = {sr[SRW-2:0], d_r};
  assign cnt_inc = cnt + 1'b1;
  assign hdr_len = org_q ? HDR_WORD : HDR_BYTE;
  assign dat_len = org_q ? DAT_WORD : DAT_BYTE;

  // header fields of the frame as it would stand after this bit
  always_comb begin
    if (org_q) begin
      hdr_op   = shifted[ADDR_W+1:ADDR_W];
      hdr_ext  = shifted[ADDR_W-1:ADDR_W-2];
      hdr_addr = {1'b0, shifted[ADDR_W-1:0]};
    end else begin
      hdr_op   = shifted[AWB+1:AWB];
      hdr_ext  = shifted[AWB-1:AWB-2];
      hdr_addr = shifted[AWB-1:0];
    end
    hdr_cmd = decode_cmd(hdr_op, hdr_ext);
  end

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sr_n    = sr;
    org_n   = org_q;
    cmd_n   = cmd_q;
    addr_n  = cmd_addr_q;
    data_n  = cmd_data_q;
    wen_n   = wen_q;
    stb_n   = 4'b0000;
    rd_go   = 1'b0;
    if (!s_r) begin
      if (state == ST_ARMED) begin
        case (cmd_q)
          CMD_WEN:   wen_n = 1'b1;
          CMD_WDS:   wen_n = 1'b0;
          CMD_WRITE: stb_n[0] = wen_q;
          CMD_ERASE: stb_n[1] = wen_q;
          CMD_ERAL:  stb_n[2] = wen_q;
          CMD_WRAL:  stb_n[3] = wen_q;
          default: ;
        endcase
      end
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (s_rise) begin
            org_n   = org_word_i;
            state_n = c_r ? ST_DEAD : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (c_rise && d_r) begin
            state_n = ST_HDR;
            cnt_n   = '0;
          end
        end
        ST_HDR: begin
          if (c_rise) begin
            sr_n  = shifted;
            cnt_n = cnt_inc;
            if (cnt_inc == hdr_len) begin
              cmd_n  = hdr_cmd;
              addr_n = hdr_addr;
              cnt_n  = '0;
              case (hdr_cmd)
                CMD_READ: begin
                  state_n = ST_READ;
                  rd_go   = 1'b1;
                end
                CMD_WRITE, CMD_WRAL: state_n = ST_DATA;
                default:             state_n = ST_ARMED;
              endcase
            end
          end
        end
        ST_DATA: begin
          if (c_rise) begin
            sr_n  = shifted;
            cnt_n = cnt_inc;
            if (cnt_inc == dat_len) begin
              data_n  = org_q ? shifted[WORD_W-1:0]
                              : {{(WORD_W-BYTE_W){1'b0}}, shifted[BYTE_W-1:0]};
              state_n = ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (c_rise) state_n = ST_DEAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sr         <= '0;
      org_q      <= 1'b1;
      cmd_q      <= CMD_READ;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
      wen_q      <= 1'b0;
      stb_q      <= 4'b0000;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      sr         <= sr_n;
      org_q      <= org_n;
      cmd_q      <= cmd_n;
      cmd_addr_q <= addr_n;
      cmd_data_q <= data_n;
      wen_q      <= wen_n;
      stb_q      <= stb_n;
    end
  end

  assign rd_go_addr = hdr_addr;
  assign rd_active  = (state == ST_READ);

  assert_idle_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_r |=> state == ST_IDLE);

  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  assert_prog_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_q) |-> ($past(wen_q) && $past(state) == ST_ARMED));

  assert_start_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR && $past(state) == ST_WAIT) |-> $past(c_rise && d_r));

  assert_frame_opens_low_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && $past(state) == ST_IDLE) |-> !$past(c_r));

endmodule

// File: rtl/eepr_reader.sv
module eepr_reader
  import eepr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W:0]   go_addr,
  input  logic              active,
  input  logic              c_rise,
  input  logic              byte_mode,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W:0]   rd_addr,
  output logic              q
);
  localparam int RCW = $clog2(WORD_W) + 1;

  logic [ADDR_W:0]   cur, cur_n, cur_inc;
  logic [WORD_W-1:0] sh, sh_n, load_val;
  logic [RCW-1:0]    rem, rem_n;
  logic              q_n;

  assign load_val = byte_mode ? {rdata[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}} : rdata;
  assign cur_inc  = byte_mode ? cur + 1'b1 : {1'b0, cur[ADDR_W-1:0] + 1'b1};

  always_comb begin
    cur_n = cur;
    sh_n  = sh;
    rem_n = rem;
    q_n   = q;
    if (go) begin
      cur_n = go_addr;
      rem_n = '0;
      q_n   = 1'b0;
    end else if (active && c_rise) begin
      if (rem == '0) begin
        q_n   = load_val[WORD_W-1];
        sh_n  = {load_val[WORD_W-2:0], 1'b0};
        rem_n = byte_mode ? RCW'(BYTE_W - 1) : RCW'(WORD_W - 1);
        cur_n = cur_inc;
      end else begin
        q_n   = sh[WORD_W-1];
        sh_n  = {sh[WORD_W-2:0], 1'b0};
        rem_n = rem - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      sh  <= '0;
      rem <= '0;
      q   <= 1'b0;
    end else begin
      cur <= cur_n;
      sh  <= sh_n;
      rem <= rem_n;
      q   <= q_n;
    end
  end

  assign rd_addr = cur;

  assert_dummy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !q);

endmodule

// File: rtl/eepr_store.sv
module eepr_store
  import eepr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        stb,
  input  logic              byte_mode,
  input  logic [ADDR_W:0]   waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W:0]   raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rows_w [DEPTH];
  logic [ADDR_W-1:0] widx, ridx;
  logic              wlane, rlane, all_op, erase_op, any_op;
  logic [WORD_W-1:0] value, mask, rword;

  assign widx     = byte_mode ? waddr[ADDR_W:1] : waddr[ADDR_W-1:0];
  assign wlane    = byte_mode & waddr[0];
  assign ridx     = byte_mode ? raddr[ADDR_W:1] : raddr[ADDR_W-1:0];
  assign rlane    = raddr[0];
  assign all_op   = stb[2] | stb[3];
  assign erase_op = stb[1] | stb[2];
  assign any_op   = |stb;

  always_comb begin
    if (erase_op)       value = '1;
    else if (byte_mode) value = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
    else                value = wdata;
    if (byte_mode && !all_op) mask = wlane ? 16'hFF00 : 16'h00FF;
    else                      mask = '1;
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [WORD_W-1:0] row_q, row_n;
    logic              hit;
    assign hit = any_op && (all_op || widx == ADDR_W'(r));
    always_comb row_n = (row_q & ~mask) | (value & mask);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row_q <= '1;
      else if (hit) row_q <= row_n;
    end
    assign rows_w[r] = row_q;
  end

  assign rword = rows_w[ridx];
  assign rdata = byte_mode ? {8'h00, rlane ? rword[15:8] : rword[7:0]} : rword;

endmodule

// File: rtl/eepr_front.sv
module eepr_front
  import eepr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              org_word_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              prog_write_o,
  output logic              prog_erase_o,
  output logic              prog_erase_all_o,
  output logic              prog_write_all_o,
  output logic [ADDR_W:0]   prog_addr_o,
  output logic [WORD_W-1:0] prog_data_o,
  output logic              prog_word_o
);
  logic              s_r, c_r, d_r, c_rise, s_rise;
  logic              rd_go, rd_active, org_q;
  logic [ADDR_W:0]   rd_go_addr, rd_addr;
  logic [3:0]        stb;
  logic [WORD_W-1:0] rdata;

  eepr_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_i), .sclk_pin(sclk_i), .sdi_pin(sdi_i),
    .s_r(s_r), .c_r(c_r), .d_r(d_r), .c_rise(c_rise), .s_rise(s_rise)
  );

  eepr_frame #(.ADDR_W(ADDR_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .s_r(s_r), .c_r(c_r), .d_r(d_r), .c_rise(c_rise),
    .s_rise(s_rise), .org_word_i(org_word_i), .rd_go(rd_go), .rd_go_addr(rd_go_addr),
    .rd_active(rd_active), .org_q(org_q), .stb_q(stb), .cmd_addr_q(prog_addr_o),
    .cmd_data_q(prog_data_o)
  );

  eepr_reader #(.ADDR_W(ADDR_W)) i_reader (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .go_addr(rd_go_addr), .active(rd_active),
    .c_rise(c_rise), .byte_mode(!org_q), .rdata(rdata), .rd_addr(rd_addr), .q(sdo_o)
  );

  eepr_store #(.ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .byte_mode(!org_q), .waddr(prog_addr_o),
    .wdata(prog_data_o), .raddr(rd_addr), .rdata(rdata)
  );

  assign sdo_oe_o         = rd_active;
  assign prog_write_o     = stb[0];
  assign prog_erase_o     = stb[1];
  assign prog_erase_all_o = stb[2];
  assign prog_write_all_o = stb[3];
  assign prog_word_o      = org_q;

  assert_oe_off_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_r |=> !sdo_oe_o);

endmodule

// File: tb/test_eepr_front.sv
module test_eepr_front;
  localparam int K_READ = 0, K_WRITE = 1, K_ERASE = 2, K_WEN = 3, K_WDS = 4,
                 K_ERAL = 5, K_WRAL = 6;
  localparam int N = 25;
  // {req[3:0], kind[2:0], org, addr[6:0], data[15:0], expected[15:0]}
  localparam logic [46:0] TBL [N] = '{
    {4'd1,  3'd0, 1'b1, 7'd5,    16'h0000, 16'hFFFF},  // R1 erased after reset
    {4'd8,  3'd1, 1'b1, 7'd5,    16'h1234, 16'h0000},  // R8 write while locked
    {4'd8,  3'd0, 1'b1, 7'd5,    16'h0000, 16'hFFFF},  // R8 unchanged
    {4'd8,  3'd3, 1'b1, 7'd0,    16'h0000, 16'h0000},  // R8 enable
    {4'd4,  3'd1, 1'b1, 7'd5,    16'h1234, 16'h0000},  // R4 write
    {4'd6,  3'd0, 1'b1, 7'd5,    16'h0000, 16'h1234},  // R6 read back
    {4'd5,  3'd1, 1'b0, 7'h0B,   16'h00AB, 16'h0000},  // R5 byte write upper half
    {4'd5,  3'd0, 1'b0, 7'h0A,   16'h0000, 16'h0034},  // R5 byte read lower half
    {4'd5,  3'd0, 1'b0, 7'h0B,   16'h0000, 16'h00AB},  // R5 byte read upper half
    {4'd5,  3'd0, 1'b1, 7'd5,    16'h0000, 16'hAB34},  // R5 word view
    {4'd12, 3'd2, 1'b1, 7'd5,    16'h0000, 16'h0000},  // R12 erase
    {4'd12, 3'd0, 1'b1, 7'd5,    16'h0000, 16'hFFFF},  // R12
    {4'd4,  3'd1, 1'b1, 7'd9,    16'hBEEF, 16'h0000},  // R4
    {4'd12, 3'd6, 1'b1, 7'd0,    16'h5A5A, 16'h0000},  // R12 write-all
    {4'd12, 3'd0, 1'b1, 7'd63,   16'h0000, 16'h5A5A},  // R12
    {4'd12, 3'd0, 1'b1, 7'd9,    16'h0000, 16'h5A5A},  // R12
    {4'd12, 3'd5, 1'b1, 7'd0,    16'h0000, 16'h0000},  // R12 erase-all
    {4'd12, 3'd0, 1'b1, 7'd0,    16'h0000, 16'hFFFF},  // R12
    {4'd12, 3'd6, 1'b0, 7'd0,    16'h003C, 16'h0000},  // R12 byte write-all
    {4'd5,  3'd0, 1'b1, 7'd20,   16'h0000, 16'h3C3C},  // R5 both halves
    {4'd12, 3'd2, 1'b0, 7'h11,   16'h0000, 16'h0000},  // R12 byte erase
    {4'd12, 3'd0, 1'b1, 7'd8,    16'h0000, 16'hFF3C},  // R12
    {4'd8,  3'd4, 1'b1, 7'd0,    16'h0000, 16'h0000},  // R8 disable
    {4'd8,  3'd1, 1'b1, 7'd3,    16'h0000, 16'h0000},  // R8 locked again
    {4'd8,  3'd0, 1'b1, 7'd3,    16'h0000, 16'h3C3C}   // R8 unchanged
  };

  logic clk = 1'b0;
  logic rst_n, sel, sclk, sdi, org;
  logic sdo, sdo_oe, p_wr, p_er, p_ea, p_wa, p_word;
  logic [6:0]  p_addr;
  logic [15:0] p_data;
  int total = 0, bad = 0;
  int stb_cnt = 0;
  logic [3:0]  last_kind;
  logic [6:0]  last_addr;
  logic [15:0] last_data;
  logic wen_m;

  always #2.5 clk = ~clk;

  eepr_front i_eepr_front (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .org_word_i(org), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .prog_write_o(p_wr),
    .prog_erase_o(p_er), .prog_erase_all_o(p_ea), .prog_write_all_o(p_wa),
    .prog_addr_o(p_addr), .prog_data_o(p_data), .prog_word_o(p_word)
  );

  always @(posedge clk) begin
    if (p_wr | p_er | p_ea | p_wa) begin
      stb_cnt   <= stb_cnt + 1;
      last_kind <= {p_wa, p_ea, p_er, p_wr};
      last_addr <= p_addr;
      last_data <= p_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cbit(input logic b, output logic qv, output logic oev);
    sdi = b; sclk = 1'b0; wait_n(4);
    sclk = 1'b1; wait_n(4);
    qv = sdo; oev = sdo_oe;
  endtask

  task automatic sel_on(input logic o);
    org = o; sclk = 1'b0; sel = 1'b1; wait_n(4);
  endtask

  task automatic sel_off();
    sel = 1'b0; sclk = 1'b0; sdi = 1'b0; wait_n(6);
  endtask

  task automatic send_body(input int kind, input logic o, input logic [6:0] addr,
                           input logic [15:0] data, input int lead, input int extra,
                           input int short_by, output logic dq, output logic doe);
    logic [1:0] op, ext;
    logic [6:0] a;
    logic qv, oev;
    int aw, dw;
    aw = o ? 6 : 7;
    dw = o ? 16 : 8;
    a = addr;
    ext = 2'b00;
    case (kind)
      K_READ:  op = 2'b10;
      K_WRITE: op = 2'b01;
      K_ERASE: op = 2'b11;
      K_WDS:   begin op = 2'b00; ext = 2'b00; end
      K_WRAL:  begin op = 2'b00; ext = 2'b01; end
      K_ERAL:  begin op = 2'b00; ext = 2'b10; end
      default: begin op = 2'b00; ext = 2'b11; end
    endcase
    if (op == 2'b00) begin
      if (o) a[5:4] = ext; else a[6:5] = ext;
    end
    for (int i = 0; i < lead; i++) cbit(1'b0, qv, oev);
    cbit(1'b1, qv, oev);
    cbit(op[1], qv, oev);
    cbit(op[0], qv, oev);
    for (int i = aw - 1; i >= 0; i--) cbit(a[i], qv, oev);
    dq = qv; doe = oev;
    if (kind == K_WRITE || kind == K_WRAL)
      for (int i = dw - 1; i >= short_by; i--) cbit(data[i], qv, oev);
    for (int i = 0; i < extra; i++) cbit(1'b0, qv, oev);
  endtask

  task automatic read_unit(input int n, output logic [15:0] v);
    logic qv, oev;
    v = '0;
    for (int i = 0; i < n; i++) begin
      cbit(1'b0, qv, oev);
      v = {v[14:0], qv};
    end
  endtask

  task automatic do_read(input logic o, input logic [6:0] a, input string tag,
                         output logic [15:0] v);
    logic dq, doe;
    sel_on(o);
    send_body(K_READ, o, a, 16'h0, 0, 0, 0, dq, doe);
    check({tag, " R6 dummy bit"}, {31'd0, dq}, 32'd0);
    read_unit(o ? 16 : 8, v);
  endtask

  task automatic prog(input int kind, input logic o, input logic [6:0] a,
                      input logic [15:0] d, input int extra, input int short_by);
    logic dq, doe;
    sel_on(o);
    send_body(kind, o, a, d, 0, extra, short_by, dq, doe);
    sel_off();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic dq, doe, fire;
    int kind, cnt0, req;
    logic [3:0] kexp;
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdi = 1'b0; org = 1'b1;
    wen_m = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    check("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
    check("R1 no strobe after reset", stb_cnt, 0);

    for (int i = 0; i < N; i++) begin
      req  = int'(TBL[i][46:43]);
      kind = int'(TBL[i][42:40]);
      cnt0 = stb_cnt;
      sel_on(TBL[i][39]);
      send_body(kind, TBL[i][39], TBL[i][38:32], TBL[i][31:16], (i % 3 == 0) ? 2 : 0,
                0, 0, dq, doe);
      if (kind == K_READ) begin
        check($sformatf("R%0d table[%0d] dummy", req, i), {31'd0, dq}, 32'd0);
        check($sformatf("R%0d table[%0d] oe in read", req, i), {31'd0, doe}, 32'd1);
        read_unit(TBL[i][39] ? 16 : 8, v);
        check($sformatf("R%0d table[%0d] data", req, i), {16'd0, v}, {16'd0, TBL[i][15:0]});
        sel_off();
      end else begin
        check($sformatf("R%0d table[%0d] oe off", req, i), {31'd0, doe}, 32'd0);
        sel_off();
        fire = wen_m && (kind == K_WRITE || kind == K_ERASE || kind == K_ERAL ||
                         kind == K_WRAL);
        check($sformatf("R%0d table[%0d] strobes", req, i), stb_cnt - cnt0, fire ? 1 : 0);
        if (fire) begin
          case (kind)
            K_WRITE: kexp = 4'b0001;
            K_ERASE: kexp = 4'b0010;
            K_ERAL:  kexp = 4'b0100;
            default: kexp = 4'b1000;
          endcase
          check($sformatf("R11 table[%0d] strobe kind", i), {28'd0, last_kind}, {28'd0, kexp});
          if (kind == K_WRITE || kind == K_ERASE)
            check($sformatf("R11 table[%0d] addr", i), {25'd0, last_addr},
                  {25'd0, TBL[i][39] ? {1'b0, TBL[i][37:32]} : TBL[i][38:32]});
          if (kind == K_WRITE || kind == K_WRAL)
            check($sformatf("R11 table[%0d] data", i), {16'd0, last_data},
                  {16'd0, TBL[i][39] ? TBL[i][31:16] : {8'h00, TBL[i][23:16]}});
        end
        if (kind == K_WEN) wen_m = 1'b1;
        if (kind == K_WDS) wen_m = 1'b0;
      end
    end

    // R7 sequential word read wrapping past the top address
    prog(K_WEN, 1'b1, 7'd0, 16'h0, 0, 0);
    prog(K_WRITE, 1'b1, 7'd63, 16'hC3A5, 0, 0);
    prog(K_WRITE, 1'b1, 7'd0, 16'h0F0F, 0, 0);
    prog(K_WRITE, 1'b1, 7'd1, 16'h1357, 0, 0);
    do_read(1'b1, 7'd63, "R7 word", v);
    check("R7 first unit", {16'd0, v}, {16'd0, 16'hC3A5});
    read_unit(16, v);
    check("R7 wrap to 0 no dummy", {16'd0, v}, {16'd0, 16'h0F0F});
    read_unit(16, v);
    check("R7 address 1", {16'd0, v}, {16'd0, 16'h1357});
    sel_off();
    check("R10 oe off after select low", {31'd0, sdo_oe}, 32'd0);

    // R7 byte stream wrap: byte 127 is word 63 upper half
    do_read(1'b0, 7'd127, "R7 byte", v);
    check("R7 byte 127", {16'd0, v}, 32'h00C3);
    read_unit(8, v);
    check("R7 byte wrap to 0", {16'd0, v}, 32'h000F);
    read_unit(8, v);
    check("R7 byte 1", {16'd0, v}, 32'h000F);
    sel_off();

    // R9 an extra clock edge cancels the write
    cnt0 = stb_cnt;
    prog(K_WRITE, 1'b1, 7'd2, 16'hAAAA, 1, 0);
    check("R9 extra clock no strobe", stb_cnt - cnt0, 0);
    do_read(1'b1, 7'd2, "R9", v);
    sel_off();
    check("R9 extra clock array unchanged", {16'd0, v}, 32'h3C3C);

    // R10 select dropped in the data field
    cnt0 = stb_cnt;
    prog(K_WRITE, 1'b1, 7'd2, 16'hAAAA, 0, 3);
    check("R10 early deselect no strobe", stb_cnt - cnt0, 0);
    do_read(1'b1, 7'd2, "R10", v);
    sel_off();
    check("R10 early deselect unchanged", {16'd0, v}, 32'h3C3C);

    // R2 select rising while the clock is high opens no frame
    cnt0 = stb_cnt;
    org = 1'b1; sclk = 1'b1; wait_n(4);
    sel = 1'b1; wait_n(4);
    send_body(K_WRITE, 1'b1, 7'd2, 16'h5555, 0, 0, 0, dq, doe);
    sel_off();
    check("R2 clock high at select no strobe", stb_cnt - cnt0, 0);
    do_read(1'b1, 7'd2, "R2", v);
    sel_off();
    check("R2 array unchanged", {16'd0, v}, 32'h3C3C);
    prog(K_WRITE, 1'b1, 7'd2, 16'h5555, 0, 0);
    check("R2 normal frame strobes", stb_cnt - cnt0, 1);
    do_read(1'b1, 7'd2, "R2 good", v);
    sel_off();
    check("R2 normal frame writes", {16'd0, v}, 32'h5555);

    // R1 reset clears the latch and the array
    rst_n = 1'b0; wait_n(3); rst_n = 1'b1; wait_n(3);
    check("R1 oe low after mid-run reset", {31'd0, sdo_oe}, 32'd0);
    cnt0 = stb_cnt;
    prog(K_WRITE, 1'b1, 7'd2, 16'h0000, 0, 0);
    check("R1 latch cleared by reset", stb_cnt - cnt0, 0);
    do_read(1'b1, 7'd2, "R1", v);
    sel_off();
    check("R1 array ones after reset", {16'd0, v}, 32'hFFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule